// File: doc/BRIEF.md
# Parallel Slave Capture Port

This block is the receive side of a synchronous parallel port in which the block is the slave. An external transmitter drives a data bus, a data-valid qualifier and a strobe clock. The block samples the bus on the strobe edge that software selects, takes either 8 or 16 bits per edge, and stores the bytes in a 32-byte FIFO. Software, or a DMA engine driven by the request output, pops the FIFO one 32-bit word at a time. The first byte received lands in the least significant byte of the word.

Flow control is based on how full the FIFO is. The ready output is high only while the block is enabled and the FIFO has room for one more transfer of the current width. A transmitter that honours it never loses data. If a transfer arrives while ready is low, it is dropped and a sticky overrun flag is set. If a read finds fewer than four bytes, it returns zero and sets a sticky underrun flag.

Configuration can change only while the block is disabled. While it is enabled, a control write can only clear the enable bit, and clearing enable empties the FIFO at once. Everything runs on the system clock. The strobe and data are passed through a short synchroniser, and the strobe is edge-detected after it.

Top module: `pscap_top`

## Requirements
- R1: Control bit 0 enables capture. A control write that clears it empties the FIFO in that cycle. While disabled, the FIFO stays empty, ready is low, and strobe edges are ignored without setting overrun.
- R2: While enabled, a control write changes only bit 0. Bits 1 to 3 keep their values until a write made while disabled. `ctl_rdata` always shows the current control value.
- R3: The FIFO holds at most 32 bytes and never holds more.
- R4: `ready` is high exactly when enabled and the free space is at least the transfer size (1 byte in 8-bit mode, 2 bytes in 16-bit mode).
- R5: Control bit 1 set samples on rising strobe edges; clear samples on falling edges. The opposite edge captures nothing, even with valid high.
- R6: Control bit 2 clear takes `ext_data[7:0]` per edge. Set takes all 16 bits, with bits 7:0 stored first.
- R7: A pulse on `rd_en` with four or more bytes buffered removes the four oldest bytes. They appear on `rd_data` in the next cycle, oldest byte in bits 7:0.
- R8: `dma_req` is high exactly when control bit 3 and bit 0 are both set and at least four bytes are buffered.
- R9: A read with fewer than four bytes buffered returns zero, leaves the FIFO unchanged and sets the sticky `underrun` flag.
- R10: A transfer that arrives while enabled and `ready` is low is discarded and sets the sticky `overrun` flag.
- R11: Writing 1 on `sts_clr[0]` clears `overrun` and writing 1 on `sts_clr[1]` clears `underrun`. A set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk | input | 1 | Strobe clock from the transmitter |
| ext_valid | input | 1 | Data-valid qualifier from the transmitter |
| ext_data | input | 16 | Parallel data bus |
| ready | output | 1 | Room for one more transfer; the transmitter pauses while low |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 4 | {dma_en, width16, sample_rising, enable} |
| ctl_rdata | output | 4 | Current control value |
| sts_clr_wr | input | 1 | Status clear strobe |
| sts_clr | input | 2 | Write-1-to-clear mask {underrun, overrun} |
| overrun | output | 1 | Sticky dropped-transfer flag |
| underrun | output | 1 | Sticky empty-read flag |
| rd_en | input | 1 | Pop one 32-bit word |
| rd_data | output | 32 | Popped word, valid the cycle after `rd_en` |
| dma_req | output | 1 | A full word is available for DMA |

## Verification
The bench builds the block with its default values: a 32-byte FIFO and a two-stage synchroniser. With 32 bytes, the full boundary is reached in 32 byte transfers or 16 halfword transfers. This lets the bench test where ready falls, the overrun drop, and the drain back to the underrun case in a short run. The two-stage synchroniser puts a fixed three-cycle delay between a strobe edge and the FIFO update. The bench spaces its strobe phases four system cycles apart, so every transfer has settled before the next one is sent.

// File: rtl/pscap_pkg.sv
package pscap_pkg;

  localparam int WORD_BYTES = 4;
  localparam int BUS_BITS   = 16;

  typedef struct packed {
    logic dma_en;
    logic width16;
    logic rise;
    logic en;
  } ctl_t;

  // bytes carried by one strobe edge for the selected width
  function automatic int xfer_bytes(input logic width16);
    return width16 ? 2 : 1;
  endfunction

  // does a transfer of n bytes fit beside fill bytes in a cap-byte store
  function automatic logic room_for(input int fill, input int n, input int cap);
    return (fill + n) <= cap;
  endfunction

  // is at least one whole word buffered
  function automatic logic word_avail(input int fill);
    return fill >= WORD_BYTES;
  endfunction

endpackage

// File: rtl/pscap_edge.sv
module pscap_edge import pscap_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_clk,
  input  logic                ext_valid,
  input  logic [BUS_BITS-1:0] ext_data,
  input  logic                rise,
  output logic                xfer_evt,
  output logic [BUS_BITS-1:0] xfer_data
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] clk_sync;
  logic [SYNC_STAGES-1:0] val_sync;
  logic [BUS_BITS-1:0]    dat_sync [SYNC_STAGES];
  logic                   clk_prev;
  logic                   edge_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sync <= '0;
      val_sync <= '0;
      clk_prev <= 1'b0;
      for (int i = 0; i < SYNC_STAGES; i++) dat_sync[i] <= '0;
    end else begin
      clk_sync    <= {clk_sync[SYNC_STAGES-2:0], ext_clk};
      val_sync    <= {val_sync[SYNC_STAGES-2:0], ext_valid};
      dat_sync[0] <= ext_data;
      for (int i = 1; i < SYNC_STAGES; i++) dat_sync[i] <= dat_sync[i-1];
      clk_prev    <= clk_sync[LAST];
    end
  end

  assign edge_hit  = rise ? (clk_sync[LAST] & ~clk_prev) : (~clk_sync[LAST] & clk_prev);
  assign xfer_evt  = edge_hit & val_sync[LAST];
  assign xfer_data = dat_sync[LAST];

endmodule

// File: rtl/pscap_ctrl.sv
module pscap_ctrl import pscap_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [3:0] ctl_wdata,
  input  logic       sts_clr_wr,
  input  logic [1:0] sts_clr,
  input  logic       set_ovr,
  input  logic       set_udr,
  output ctl_t       ctl_q,
  output logic       flush,
  output logic       ovr_q,
  output logic       udr_q
);

  ctl_t wr_val;
  assign wr_val = ctl_t'(ctl_wdata);

  // a write that clears enable while running empties the store
  assign flush = ctl_wr & ctl_q.en & ~wr_val.en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_wr) begin
      if (ctl_q.en) ctl_q.en <= wr_val.en;
      else          ctl_q    <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      udr_q <= 1'b0;
    end else begin
      ovr_q <= set_ovr | (ovr_q & ~(sts_clr_wr & sts_clr[0]));
      udr_q <= set_udr | (udr_q & ~(sts_clr_wr & sts_clr[1]));
    end
  end

endmodule

// File: rtl/pscap_fifo.sv
module pscap_fifo import pscap_pkg::*; #(
  parameter int FIFO_BYTES = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush,
  input  logic                            push,
  input  logic                            push_two,
  input  logic [BUS_BITS-1:0]             push_data,
  input  logic                            pop,
  output logic [8*WORD_BYTES-1:0]         head_word,
  output logic [$clog2(FIFO_BYTES):0]     fill
);

  localparam int AW = $clog2(FIFO_BYTES);
  localparam int FW = AW + 1;

  logic [7:0]    mem [FIFO_BYTES];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [FW-1:0] fill_q, add_n, sub_n;

  assign add_n = push ? (push_two ? FW'(2) : FW'(1)) : '0;
  assign sub_n = pop ? FW'(WORD_BYTES) : '0;
  assign fill  = fill_q;

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr] <= push_data[7:0];
      if (push_two) mem[wr_ptr + AW'(1)] <= push_data[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill_q <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + (push_two ? AW'(2) : AW'(1));
      if (pop)  rd_ptr <= rd_ptr + AW'(WORD_BYTES);
      fill_q <= fill_q + add_n - sub_n;
    end
  end

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_word
    assign head_word[8*k +: 8] = mem[rd_ptr + AW'(k)];
  end

endmodule

// File: rtl/pscap_top.sv
module pscap_top import pscap_pkg::*; #(
  parameter int FIFO_BYTES  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_clk,
  input  logic        ext_valid,
  input  logic [15:0] ext_data,
  output logic        ready,
  input  logic        ctl_wr,
  input  logic [3:0]  ctl_wdata,
  output logic [3:0]  ctl_rdata,
  input  logic        sts_clr_wr,
  input  logic [1:0]  sts_clr,
  output logic        overrun,
  output logic        underrun,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  output logic        dma_req
);

  localparam int FW = $clog2(FIFO_BYTES) + 1;

  ctl_t                ctl_q;
  logic                flush;
  logic                xfer_evt;
  logic [BUS_BITS-1:0] xfer_data;
  logic [FW-1:0]       fill;
  logic [31:0]         head_word;
  logic                has_room;
  logic                has_word;
  logic                accept_evt;
  logic                drop_evt;
  logic                pop_evt;
  logic                empty_rd_evt;

  pscap_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_clk   (ext_clk),
    .ext_valid (ext_valid),
    .ext_data  (ext_data),
    .rise      (ctl_q.rise),
    .xfer_evt  (xfer_evt),
    .xfer_data (xfer_data)
  );

  assign has_room     = room_for(int'(fill), xfer_bytes(ctl_q.width16), FIFO_BYTES);
  assign has_word     = word_avail(int'(fill));
  assign accept_evt   = xfer_evt & ctl_q.en & has_room;
  assign drop_evt     = xfer_evt & ctl_q.en & ~has_room;
  assign pop_evt      = rd_en & has_word;
  assign empty_rd_evt = rd_en & ~has_word;

  pscap_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .sts_clr_wr (sts_clr_wr),
    .sts_clr    (sts_clr),
    .set_ovr    (drop_evt),
    .set_udr    (empty_rd_evt),
    .ctl_q      (ctl_q),
    .flush      (flush),
    .ovr_q      (overrun),
    .udr_q      (underrun)
  );

  pscap_fifo #(.FIFO_BYTES(FIFO_BYTES)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (accept_evt),
    .push_two  (ctl_q.width16),
    .push_data (xfer_data),
    .pop       (pop_evt),
    .head_word (head_word),
    .fill      (fill)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_data <= '0;
    else if (rd_en)   rd_data <= has_word ? head_word : '0;
  end

  assign ready     = ctl_q.en & has_room;
  assign dma_req   = ctl_q.en & ctl_q.dma_en & has_word;
  assign ctl_rdata = ctl_q;

endmodule

// File: rtl/pscap_checker.sv
module pscap_checker #(
  parameter int FIFO_BYTES = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [3:0]                  ctl_rdata,
  input logic [$clog2(FIFO_BYTES):0] fill,
  input logic                        drop_evt,
  input logic                        rd_en,
  input logic [31:0]                 rd_data,
  input logic                        overrun,
  input logic                        underrun,
  input logic                        dma_req
);

  assert_disabled_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[0] |-> fill == '0);

  assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[0] && $past(ctl_rdata[0])) |-> $stable(ctl_rdata[3:1]));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= FIFO_BYTES);

  assert_dma_has_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> int'(fill) >= 4);

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(fill) < 4) |=> (underrun && rd_data == 32'h0 && $stable(fill)));

  assert_drop_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> overrun);

endmodule

bind pscap_top pscap_checker #(.FIFO_BYTES(FIFO_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_rdata (ctl_rdata),
  .fill      (fill),
  .drop_evt  (drop_evt),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .overrun   (overrun),
  .underrun  (underrun),
  .dma_req   (dma_req)
);

// File: tb/pscap_top_tb.sv
`timescale 1ns/1ps
module pscap_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk = 1'b0;
  logic        ext_valid = 1'b0;
  logic [15:0] ext_data = '0;
  logic        ready;
  logic        ctl_wr = 1'b0;
  logic [3:0]  ctl_wdata = '0;
  logic [3:0]  ctl_rdata;
  logic        sts_clr_wr = 1'b0;
  logic [1:0]  sts_clr = '0;
  logic        overrun;
  logic        underrun;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        dma_req;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pscap_top u_dut (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .ext_valid(ext_valid),
    .ext_data(ext_data), .ready(ready), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .sts_clr_wr(sts_clr_wr), .sts_clr(sts_clr),
    .overrun(overrun), .underrun(underrun), .rd_en(rd_en), .rd_data(rd_data),
    .dma_req(dma_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [3:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic clr_sts(input logic [1:0] m);
    @(negedge clk); sts_clr_wr = 1'b1; sts_clr = m;
    @(negedge clk); sts_clr_wr = 1'b0;
  endtask

  task automatic rd_word(output logic [31:0] w);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; w = rd_data;
  endtask

  // one strobe pulse: idle level, active edge, back to idle
  task automatic xfer(input logic [15:0] d, input logic rise, input logic hold_valid);
    ext_clk = ~rise; ext_data = d; ext_valid = 1'b1;
    repeat (4) @(negedge clk);
    ext_clk = rise;
    repeat (4) @(negedge clk);
    if (!hold_valid) ext_valid = 1'b0;
    ext_clk = ~rise;
    repeat (4) @(negedge clk);
    ext_valid = 1'b0;
  endtask

  task automatic idle_state();
    wr_ctl(4'b0000);
    wr_ctl(4'b0000);
    clr_sts(2'b11);
  endtask

  task automatic t_reset();
    check("R1 reset ready", ready, 0);
    check("R8 reset dma_req", dma_req, 0);
    check("R10 reset overrun", overrun, 0);
    check("R9 reset underrun", underrun, 0);
    check("R2 reset ctl", ctl_rdata, 0);
  endtask

  task automatic t_byte_pack();
    logic [31:0] w;
    idle_state();
    wr_ctl(4'b0011);
    check("R4 ready after enable", ready, 1);
    for (int i = 0; i < 8; i++) xfer({8'hAA, 8'h11 + 8'(i)}, 1'b1, 1'b0);
    rd_word(w); check("R7 byte word0", w, 32'h14131211);
    rd_word(w); check("R6 byte word1", w, 32'h18171615);
  endtask

  task automatic t_half_pack();
    logic [31:0] w;
    idle_state();
    wr_ctl(4'b0111);
    xfer(16'h1234, 1'b1, 1'b0); xfer(16'h5678, 1'b1, 1'b0);
    xfer(16'h9ABC, 1'b1, 1'b0); xfer(16'hDEF0, 1'b1, 1'b0);
    rd_word(w); check("R6 half word0", w, 32'h56781234);
    rd_word(w); check("R7 half word1", w, 32'hDEF09ABC);
  endtask

  task automatic t_full_bytes();
    logic [31:0] w;
    idle_state();
    wr_ctl(4'b0011);
    for (int i = 0; i < 31; i++) xfer({8'h00, 8'h40 + 8'(i)}, 1'b1, 1'b0);
    check("R4 ready at 31 bytes", ready, 1);
    xfer(16'h005F, 1'b1, 1'b0);
    check("R4 ready low at 32 bytes", ready, 0);
    check("R10 no overrun at full", overrun, 0);
    xfer(16'h00EE, 1'b1, 1'b0);
    check("R10 overrun on drop", overrun, 1);
    for (int j = 0; j < 8; j++) begin
      logic [7:0] b0;
      b0 = 8'h40 + 8'(4*j);
      rd_word(w);
      check("R3 drain word", w, {b0 + 8'd3, b0 + 8'd2, b0 + 8'd1, b0});
      if (j == 0) check("R4 ready after one pop", ready, 1);
    end
    rd_word(w); check("R3 dropped byte absent", w, 32'h0);
    check("R9 underrun after drain", underrun, 1);
    clr_sts(2'b01);
    check("R11 overrun cleared", overrun, 0);
    check("R11 underrun kept", underrun, 1);
    clr_sts(2'b10);
    check("R11 underrun cleared", underrun, 0);
  endtask

  task automatic t_full_halves();
    logic [31:0] w;
    idle_state();
    wr_ctl(4'b0111);
    for (int i = 0; i < 15; i++) xfer(16'(i), 1'b1, 1'b0);
    check("R4 ready at 30 bytes 16-bit", ready, 1);
    xfer(16'h00FF, 1'b1, 1'b0);
    check("R4 ready low at 32 bytes 16-bit", ready, 0);
    rd_word(w);
    check("R4 ready after pop 16-bit", ready, 1);
    check("R7 first halves", w, 32'h00010000);
  endtask

  task automatic t_underrun();
    logic [31:0] w;
    idle_state();
    wr_ctl(4'b0011);
    xfer(16'h00A1, 1'b1, 1'b0); xfer(16'h00A2, 1'b1, 1'b0); xfer(16'h00A3, 1'b1, 1'b0);
    rd_word(w);
    check("R9 short read zero", w, 32'h0);
    check("R9 underrun set", underrun, 1);
    xfer(16'h00A4, 1'b1, 1'b0);
    rd_word(w);
    check("R9 bytes kept after short read", w, 32'hA4A3A2A1);
  endtask

  task automatic t_dma();
    logic [31:0] w;
    idle_state();
    wr_ctl(4'b0011);
    for (int i = 0; i < 4; i++) xfer(16'h0001, 1'b1, 1'b0);
    check("R8 no request without dma_en", dma_req, 0);
    idle_state();
    wr_ctl(4'b1011);
    for (int i = 0; i < 3; i++) xfer(16'h0002, 1'b1, 1'b0);
    check("R8 no request at 3 bytes", dma_req, 0);
    xfer(16'h0002, 1'b1, 1'b0);
    check("R8 request at 4 bytes", dma_req, 1);
    rd_word(w);
    check("R8 request drops after pop", dma_req, 0);
  endtask

  task automatic t_lock();
    idle_state();
    wr_ctl(4'b0011);
    wr_ctl(4'b1111);
    check("R2 config locked", ctl_rdata, 4'b1111 & 4'b0011);
    wr_ctl(4'b0110);
    check("R2 disable keeps config", ctl_rdata, 4'b0010);
    wr_ctl(4'b0111);
    check("R2 config applies when off", ctl_rdata, 4'b0111);
  endtask

  task automatic t_flush();
    logic [31:0] w;
    idle_state();
    wr_ctl(4'b1011);
    for (int i = 0; i < 8; i++) xfer(16'h0033, 1'b1, 1'b0);
    check("R8 request before flush", dma_req, 1);
    wr_ctl(4'b0000);
    check("R1 ready low when off", ready, 0);
    xfer(16'h0044, 1'b1, 1'b0);
    check("R1 no overrun when off", overrun, 0);
    wr_ctl(4'b1011);
    check("R1 no request after flush", dma_req, 0);
    rd_word(w);
    check("R1 flushed read zero", w, 32'h0);
    check("R1 flushed read underrun", underrun, 1);
  endtask

  task automatic t_polarity();
    logic [31:0] w;
    idle_state();
    wr_ctl(4'b0001);
    for (int i = 0; i < 4; i++) xfer({8'h00, 8'hC0 + 8'(i)}, 1'b0, 1'b1);
    rd_word(w);
    check("R5 falling edge capture", w, 32'hC3C2C1C0);
    rd_word(w);
    check("R5 rising edges ignored", w, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_pack();
    t_half_pack();
    t_full_bytes();
    t_full_halves();
    t_underrun();
    t_dma();
    t_lock();
    t_flush();
    t_polarity();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule